// File: doc/BRIEF.md
# Dual Output Compare Flag Unit

This block watches a running timer count and compares it, every clock, against two compare values held in registers, one for channel A and one for channel B. Each channel drives a match strobe while the count equals its compare value; a downstream waveform generator combines that strobe with its own mode settings. The compare flag does not follow the comparator directly. It is set at the clock edge where the timer advances (tick enable high) while the count still equals the compare value, so the flag shows up one timer tick after the count reached the match.

Each flag can raise an interrupt request when its channel's enable bit is set. A flag is cleared either by a one-cycle acknowledge pulse from the interrupt controller or by software writing a one to the flag's bit; writing zero leaves it untouched. A small CPU register port gives write access and combinational read access to both compare values, the enable bits and the flags.

Top module: `ocf_dual_unit`

## Requirements
- R1: After reset both compare registers read 0x00, the enable and flag registers read 0x00, and both interrupt requests are low.
- R2: match[i] is high in exactly those cycles where count equals channel i's compare register.
- R3: Flag i is set at a rising clock edge only when tick is high and count equals compare register i at that edge; it is visible from the following cycle. While tick is low no flag is set.
- R4: The two channels are independent: a match, write or acknowledge on one channel leaves the other channel's flag and compare value unchanged.
- R5: irq[i] is high exactly when flag i is set and enable bit i is set.
- R6: A high irq_ack[i] at a clock edge clears flag i.
- R7: A write to address 3 clears flag i for each bit i (bit 0 = A, bit 1 = B) of the written data that is one; bits written zero have no effect.
- R8: When a set condition (R3) and a clear (R6 or R7) hit the same flag at the same edge, the flag ends up set.
- R9: Register map: address 0 is compare A, address 1 is compare B (8 bits each, read/write); address 2 holds the interrupt enables in bit 0 (A) and bit 1 (B); address 3 holds the flags in the same bit positions. Unused bits read 0 and read data follows rd_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timer advance enable for this cycle |
| count | input | 8 | Current timer count |
| wr_en | input | 1 | CPU register write strobe |
| wr_addr | input | 2 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rd_addr | input | 2 | CPU read address |
| rd_data | output | 8 | CPU read data |
| irq_ack | input | 2 | Interrupt service pulse per channel (bit 0 = A) |
| irq | output | 2 | Interrupt request per channel |
| match | output | 2 | Comparator strobe per channel to the waveform generator |

## Verification
The assertions take for granted that the timer presents a count that is valid at every clock edge and that irq_ack, wr_en and tick are sampled as plain level signals, with no requirement that acknowledges arrive only for set flags. The stimulus keeps a random count but steers it onto a current compare value about a quarter of the time, so set conditions collide often with acknowledges, write-one clears and compare rewrites. Directed sequences then pin down the stalled-tick case, the set-beats-clear case and the write-zero case on each channel.

// File: rtl/ocf_pkg.sv
package ocf_pkg;

    typedef enum logic [1:0] {
        SEL_CMP  = 2'd0,
        SEL_IEN  = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Compare registers occupy the lowest addresses, one per channel,
    // followed by the enable register and the flag register.
    function automatic reg_sel_e decode_addr(input int addr, input int nch);
        if (addr < nch)            return SEL_CMP;
        else if (addr == nch)      return SEL_IEN;
        else if (addr == nch + 1)  return SEL_FLAG;
        else                       return SEL_NONE;
    endfunction

endpackage

// File: rtl/ocf_channel.sv
module ocf_channel #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             flag_w1c,
    input  logic             flag_ack,
    output logic [CNT_W-1:0] cmp_q,
    output logic             flag_q,
    output logic             match
);

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             flag;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      set_req;
    logic      clr_req;

    always_comb begin
        match   = (count == st_q.cmp);
        set_req = tick && match;
        clr_req = flag_w1c || flag_ack;
        st_d    = st_q;
        if (cmp_we) begin
            st_d.cmp = cmp_wdata;
        end
        if (set_req) begin
            st_d.flag = 1'b1;
        end else if (clr_req) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp_q  = st_q.cmp;
    assign flag_q = st_q.flag;

    // R3: a flag only rises after an edge that saw tick with a match
    a_r3_rise_needs_tick_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick && (count == cmp_q)));

    // R3: stalled timer sets nothing
    a_r3_no_set_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !$rose(flag_q));

    // R8: a set condition always leaves the flag high
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && match) |=> flag_q);

    // R6 / R7: a clear without a competing set drops the flag
    a_r6_clear_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_w1c || flag_ack) && !(tick && match)) |=> !flag_q);

    // R9: compare value only changes through a write
    a_r9_cmp_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_we |=> $stable(cmp_q));

endmodule

// File: rtl/ocf_ctrl.sv
module ocf_ctrl
    import ocf_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [CNT_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [NUM_CH*CNT_W-1:0] cmp_all,
    input  logic [NUM_CH-1:0]       flags,
    output logic [NUM_CH-1:0]       cmp_we,
    output logic [NUM_CH-1:0]       flag_w1c,
    output logic [NUM_CH-1:0]       ien_q,
    output logic [CNT_W-1:0]        rd_data
);

    typedef struct packed {
        logic [NUM_CH-1:0] ien;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    reg_sel_e   wr_sel;
    reg_sel_e   rd_sel;

    always_comb begin
        wr_sel   = decode_addr(int'(wr_addr), NUM_CH);
        rd_sel   = decode_addr(int'(rd_addr), NUM_CH);
        st_d     = st_q;
        cmp_we   = '0;
        flag_w1c = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            cmp_we[i]   = wr_en && (wr_sel == SEL_CMP) && (int'(wr_addr) == i);
            flag_w1c[i] = wr_en && (wr_sel == SEL_FLAG) && wr_data[i];
        end
        if (wr_en && (wr_sel == SEL_IEN)) begin
            st_d.ien = wr_data[NUM_CH-1:0];
        end

        rd_data = '0;
        unique case (rd_sel)
            SEL_CMP: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (int'(rd_addr) == i) begin
                        rd_data = cmp_all[i*CNT_W +: CNT_W];
                    end
                end
            end
            SEL_IEN:  rd_data[NUM_CH-1:0] = st_q.ien;
            SEL_FLAG: rd_data[NUM_CH-1:0] = flags;
            default:  rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ien_q = st_q.ien;

    // R9: enables only change through a write to their address
    a_r9_ien_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (int'(wr_addr) == NUM_CH)) |=> $stable(ien_q));

    // R7: at most one compare register is written per cycle
    a_r7_single_cmp_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmp_we));

endmodule

// File: rtl/ocf_dual_unit.sv
module ocf_dual_unit #(
    parameter int CNT_W  = 8,
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [CNT_W-1:0]  count,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [1:0]        rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic [NUM_CH-1:0] irq_ack,
    output logic [NUM_CH-1:0] irq,
    output logic [NUM_CH-1:0] match
);

    localparam int ADDR_W = 2;

    logic [NUM_CH*CNT_W-1:0] cmp_all;
    logic [NUM_CH-1:0]       flags;
    logic [NUM_CH-1:0]       cmp_we;
    logic [NUM_CH-1:0]       flag_w1c;
    logic [NUM_CH-1:0]       ien;

    ocf_ctrl #(
        .CNT_W  (CNT_W),
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .cmp_all  (cmp_all),
        .flags    (flags),
        .cmp_we   (cmp_we),
        .flag_w1c (flag_w1c),
        .ien_q    (ien),
        .rd_data  (rd_data)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ocf_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .count     (count),
            .cmp_we    (cmp_we[g]),
            .cmp_wdata (wr_data),
            .flag_w1c  (flag_w1c[g]),
            .flag_ack  (irq_ack[g]),
            .cmp_q     (cmp_all[g*CNT_W +: CNT_W]),
            .flag_q    (flags[g]),
            .match     (match[g])
        );
    end

    assign irq = flags & ien;

    // R5: a request never outlives the acknowledge that serviced it
    a_r6_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack[0] && !(tick && match[0])) |=> !irq[0]);

endmodule

// File: tb/sim_ocf_dual_unit.sv
module sim_ocf_dual_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] count = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] irq_ack = '0;
    logic [1:0] irq;
    logic [1:0] match;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] m_cmp [2];
    logic [1:0] m_ien;
    logic [1:0] m_flag;

    always #10 clk = ~clk;

    ocf_dual_unit u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .count   (count),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq_ack (irq_ack),
        .irq     (irq),
        .match   (match)
    );

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return m_cmp[0];
            2'd1:    return m_cmp[1];
            2'd2:    return {6'b0, m_ien};
            default: return {6'b0, m_flag};
        endcase
    endfunction

    function automatic logic [1:0] exp_match();
        return {count == m_cmp[1], count == m_cmp[0]};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, expv, $time);
        end
    endtask

    // Checks outputs mid-cycle, then lets one clock edge pass and updates the model.
    task automatic step();
        #5;
        chk("R2 match", {6'b0, match}, {6'b0, exp_match()});
        chk("R5 irq", {6'b0, irq}, {6'b0, m_flag & m_ien});
        chk(rd_addr == 2'd3 ? "R7 flag read" : "R9 read", rd_data, exp_read(rd_addr));
        @(posedge clk);
        for (int i = 0; i < 2; i++) begin
            logic setc;
            logic clrc;
            setc = tick && (count == m_cmp[i]);
            clrc = irq_ack[i] || (wr_en && wr_addr == 2'd3 && wr_data[i]);
            if (setc) m_flag[i] = 1'b1;
            else if (clrc) m_flag[i] = 1'b0;
        end
        if (wr_en && wr_addr < 2'd2) m_cmp[wr_addr[0]] = wr_data;
        if (wr_en && wr_addr == 2'd2) m_ien = wr_data[1:0];
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; irq_ack = '0;
    endtask

    task automatic write(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
    endtask

    task automatic flag_chk(input string tag, input logic [1:0] expv);
        rd_addr = 2'd3;
        #5;
        chk(tag, rd_data, {6'b0, expv});
        chk(tag, {6'b0, m_flag}, {6'b0, expv});
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        m_cmp[0] = '0; m_cmp[1] = '0; m_ien = '0; m_flag = '0;
        #35;
        // R1: reset values at every address
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #1;
            chk("R1 reset read", rd_data, 8'h00);
        end
        chk("R1 reset irq", {6'b0, irq}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        write(2'd0, 8'h40);
        write(2'd1, 8'h41);
        write(2'd2, 8'h03);

        // R3: stalled tick with count on match sets nothing
        count = 8'h40; tick = 1'b0; step();
        flag_chk("R3 stalled", 2'b00);
        // R3 / R4: tick on match sets only channel A
        count = 8'h40; tick = 1'b1; step();
        flag_chk("R4 only A set", 2'b01);
        chk("R5 irq A", {6'b0, irq}, 8'h01);
        // R8: set of B collides with write-one clear of B
        count = 8'h41; tick = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h02; step();
        flag_chk("R8 set beats clear", 2'b11);
        // R7: writing zeros leaves flags alone
        write(2'd3, 8'h00);
        flag_chk("R7 write zero", 2'b11);
        // R6: acknowledge clears A only
        count = 8'h00; irq_ack = 2'b01; step();
        flag_chk("R6 ack A", 2'b10);
        // R7: write-one clears B
        write(2'd3, 8'h02);
        flag_chk("R7 w1c B", 2'b00);

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            tick    = ($urandom % 3) != 0;
            count   = (($urandom % 4) == 0) ? m_cmp[$urandom % 2] : 8'($urandom);
            wr_en   = ($urandom % 5) == 0;
            wr_addr = 2'($urandom);
            wr_data = 8'($urandom);
            rd_addr = 2'($urandom);
            irq_ack = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
            step();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule